// File: doc/BRIEF.md
# Transmit Byte Queue with Committed Writes

This block holds outgoing serial bytes for a high-speed UART. The host places bytes into a staging window and then publishes them in one step by writing a byte count to a control register. Bytes staged in the window stay invisible to the transmitter until that count is written. A single control-register read returns both the host's insertion pointer and the number of bytes still waiting.

The transmit side presents one byte at a time with a valid/ready handshake, draining the queue in commit order. A space indicator tells the host that room has opened up. It is asserted when the waiting count falls below a level chosen by a 3-bit code, and it can be switched off by an enable input. The bus decode, which turns host addresses into the window and control strobes, sits outside this block, and so does the serializer.

Top module: `tx_commit_fifo`

## Requirements
- R1: After reset the control readback is all zero, meaning insertion pointer 0 and waiting count 0, and `tx_valid` is low.
- R2: Writes into the staging window change neither the control readback nor `tx_valid` until a commit is written.
- R3: A commit of N, taken from `ctl_wdata[9:0]` while `ctl_we` is high, advances the insertion pointer and the waiting count by N. The readback places the pointer in bits 9:0 and the count in bits 25:16, and every other bit reads 0.
- R4: A byte written at window offset k sits at queue position pointer+k. After a commit, bytes reach `tx_data` in pointer order, starting from the oldest committed byte.
- R5: `tx_valid` is high whenever the waiting count is non-zero. Each cycle in which both `tx_valid` and `tx_ready` are high removes one byte and lowers the count by 1.
- R6: A commit and a removal in the same cycle are both counted, so the count becomes old + N - 1.
- R7: The waiting count never exceeds 1020. A commit larger than 1020 minus the current count is reduced to that free space, and the pointer advances by the reduced amount only.
- R8: With the space enable high, `tx_space` is high exactly when the waiting count is below 4 << code. For example, code 5 gives 128 and code 7 gives 512.
- R9: With the space enable low, `tx_space` is low.
- R10: A waiting count of 0 means the transmitter is empty. In that state `tx_valid` is low, and `tx_ready` has no effect on the readback.
- R11: The insertion pointer wraps modulo 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_we | input | 1 | Staging window byte write strobe |
| win_off | input | 10 | Window offset relative to the insertion pointer |
| win_data | input | 8 | Byte to stage |
| ctl_we | input | 1 | Commit strobe (write of the control register) |
| ctl_wdata | input | 32 | Control write data; bits 9:0 hold the commit count |
| ctl_rdata | output | 32 | Readback: pointer in 9:0, waiting count in 25:16 |
| cfg_level | input | 3 | Space-level code, threshold 4 << code |
| cfg_space_en | input | 1 | Enables the space indicator |
| tx_valid | output | 1 | A byte is waiting for the serializer |
| tx_data | output | 8 | Oldest waiting byte |
| tx_ready | input | 1 | Serializer accepts the byte |
| tx_space | output | 1 | Waiting count below the programmed level |

## Verification
A commit or a removal is visible on the readback one clock edge after its strobe. For this reason the bench drives every strobe just after a rising edge, holds it for one edge, and reads the result at the following falling edge. `tx_space` follows the count and the level code combinationally, so it is sampled at the falling edge of the same cycle in which the code changes or the count settles. `tx_data` is read combinationally from the removal pointer. The scoreboard monitor therefore compares it at the falling edge of every cycle in which both `tx_valid` and `tx_ready` are high, before the edge that consumes the byte.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

  localparam int unsigned CTL_FILL_LSB = 16;
  localparam int unsigned LEVEL_UNIT   = 4;

  // Amount actually accepted from a commit request given the free room.
  function automatic int unsigned clip_grant(input int unsigned req,
                                             input int unsigned fill,
                                             input int unsigned cap);
    int unsigned room;
    room = (fill >= cap) ? 0 : cap - fill;
    return (req > room) ? room : req;
  endfunction

  // Threshold in bytes selected by a level code.
  function automatic int unsigned level_bytes(input logic [2:0] code,
                                              input int unsigned unit);
    return unit << code;
  endfunction

endpackage

// File: rtl/tfc_store.sv
module tfc_store #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/tfc_ptrs.sv
module tfc_ptrs #(
  parameter int unsigned AW   = 10,
  parameter int unsigned CAP  = 1020,
  parameter int unsigned CNTW = $clog2(CAP + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit_req,
  input  logic [AW-1:0]   commit_len,
  input  logic            pop,
  output logic [AW-1:0]   wptr,
  output logic [AW-1:0]   rptr,
  output logic [CNTW-1:0] fill,
  output logic [CNTW-1:0] grant
);

  logic [CNTW-1:0] add_amt;
  logic [CNTW-1:0] sub_amt;

  always_comb begin
    grant   = CNTW'(tfc_pkg::clip_grant(int'(unsigned'(commit_len)),
                                        int'(unsigned'(fill)), CAP));
    add_amt = commit_req ? grant : '0;
    sub_amt = pop ? CNTW'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (commit_req) wptr <= wptr + AW'(grant);
      if (pop)        rptr <= rptr + AW'(1);
      fill <= fill + add_amt - sub_amt;
    end
  end

endmodule

// File: rtl/tfc_level.sv
module tfc_level #(
  parameter int unsigned CNTW = 10,
  parameter int unsigned UNIT = tfc_pkg::LEVEL_UNIT
) (
  input  logic [2:0]      code,
  input  logic            en,
  input  logic [CNTW-1:0] fill,
  output logic            space
);

  logic [CNTW+8:0] thresh;

  always_comb begin
    thresh = (CNTW+9)'(tfc_pkg::level_bytes(code, UNIT));
    space  = en && ((CNTW+9)'(fill) < thresh);
  end

endmodule

// File: rtl/tx_commit_fifo.sv
module tx_commit_fifo #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned CAP   = 1020
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        win_we,
  input  logic [9:0]  win_off,
  input  logic [7:0]  win_data,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_rdata,
  input  logic [2:0]  cfg_level,
  input  logic        cfg_space_en,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  output logic        tx_space
);

  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned CNTW = $clog2(CAP + 1);

  // Named internal events, exposed for the bound checker.
  logic            pop_evt;
  logic            commit_evt;
  logic [CNTW-1:0] grant_len;
  logic [AW-1:0]   wptr;
  logic [AW-1:0]   rptr;
  logic [CNTW-1:0] fill;
  logic [AW-1:0]   stage_addr;

  assign commit_evt = ctl_we;
  assign pop_evt    = tx_valid && tx_ready;
  assign stage_addr = wptr + AW'(win_off);
  assign tx_valid   = (fill != '0);

  tfc_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .wr_en   (win_we),
    .wr_addr (stage_addr),
    .wr_data (win_data),
    .rd_addr (rptr),
    .rd_data (tx_data)
  );

  tfc_ptrs #(.AW(AW), .CAP(CAP), .CNTW(CNTW)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_req (commit_evt),
    .commit_len (ctl_wdata[AW-1:0]),
    .pop        (pop_evt),
    .wptr       (wptr),
    .rptr       (rptr),
    .fill       (fill),
    .grant      (grant_len)
  );

  tfc_level #(.CNTW(CNTW)) u_level (
    .code  (cfg_level),
    .en    (cfg_space_en),
    .fill  (fill),
    .space (tx_space)
  );

  always_comb begin
    ctl_rdata = '0;
    ctl_rdata[AW-1:0] = wptr;
    ctl_rdata[tfc_pkg::CTL_FILL_LSB +: CNTW] = fill;
  end

endmodule

// File: rtl/tx_commit_fifo_chk.sv
module tx_commit_fifo_chk #(
  parameter int unsigned CAP  = 1020,
  parameter int unsigned CNTW = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ctl_we,
  input logic            win_we,
  input logic [31:0]     ctl_rdata,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic            tx_space,
  input logic            cfg_space_en,
  input logic [CNTW-1:0] grant_len,
  input logic            pop_evt
);

  logic [9:0] rd_fill;
  logic [9:0] rd_wptr;
  assign rd_fill = ctl_rdata[25:16];
  assign rd_wptr = ctl_rdata[9:0];

  assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && !(tx_valid && tx_ready)) |=> $stable(ctl_rdata));

  assert_commit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> rd_wptr == 10'($past(rd_wptr) + 10'($past(grant_len))));

  assert_pop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !ctl_we) |=> rd_fill == $past(rd_fill) - 10'd1);

  assert_both_counted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && pop_evt) |=>
      rd_fill == 10'($past(rd_fill) + 10'($past(grant_len)) - 10'd1));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fill <= 10'(CAP));

  assert_space_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_space_en |-> !tx_space);

  assert_empty_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fill == 10'd0) |-> !tx_valid);

endmodule

bind tx_commit_fifo tx_commit_fifo_chk #(.CAP(CAP), .CNTW(CNTW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctl_we       (ctl_we),
  .win_we       (win_we),
  .ctl_rdata    (ctl_rdata),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_space     (tx_space),
  .cfg_space_en (cfg_space_en),
  .grant_len    (grant_len),
  .pop_evt      (pop_evt)
);

// File: tb/tb_tx_commit_fifo.sv
module tb_tx_commit_fifo;

  localparam int CAP = 1020;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_we = 1'b0;
  logic [9:0]  win_off = '0;
  logic [7:0]  win_data = '0;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic [2:0]  cfg_level = 3'd5;
  logic        cfg_space_en = 1'b1;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic        tx_space;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] expq[$];
  logic [7:0] pend[$];
  int exp_fill = 0;
  int exp_wp   = 0;
  int seq      = 0;

  always #10 clk = ~clk;

  tx_commit_fifo dut (
    .clk(clk), .rst_n(rst_n), .win_we(win_we), .win_off(win_off),
    .win_data(win_data), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .cfg_level(cfg_level),
    .cfg_space_en(cfg_space_en), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_space(tx_space)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rd_fill();
    return int'(ctl_rdata[25:16]);
  endfunction

  function automatic int rd_wptr();
    return int'(ctl_rdata[9:0]);
  endfunction

  // Monitor: compare every handed-over byte against the scoreboard queue (R4).
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4 unexpected byte", int'(tx_data), -1);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(tx_data == e, "R4 byte order", int'(tx_data), int'(e));
        exp_fill--;
      end
    end
  end

  // Driver: stage n bytes at window offsets 0..n-1.
  task automatic stage(input int n);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      b = 8'((seq * 7 + 3) & 8'hff);
      seq++;
      win_we = 1'b1; win_off = 10'(k); win_data = b;
      pend.push_back(b);
      @(posedge clk); #1;
    end
    win_we = 1'b0;
  endtask

  // Driver: commit a request, push the granted bytes into the scoreboard.
  task automatic commit(input int req, input bit with_pop);
    int g;
    g = (req > CAP - exp_fill) ? CAP - exp_fill : req;
    for (int k = 0; k < g; k++) expq.push_back(pend[k]);
    pend.delete();
    exp_fill += g;
    exp_wp = (exp_wp + g) % 1024;
    ctl_we = 1'b1; ctl_wdata = 32'(req);
    if (with_pop) tx_ready = 1'b1;
    @(posedge clk); #1;
    ctl_we = 1'b0; ctl_wdata = '0;
    tx_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain(input bit toggle);
    int guard;
    guard = 0;
    while (rd_fill() != 0 && guard < 5000) begin
      @(posedge clk); #1;
      tx_ready = toggle ? ~tx_ready : 1'b1;
      guard++;
    end
    @(posedge clk); #1;
    tx_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(ctl_rdata == 32'd0, "R1 readback after reset", int'(ctl_rdata), 0);
    chk(tx_valid == 1'b0, "R1 valid after reset", int'(tx_valid), 0);

    // R2: staged bytes stay hidden
    stage(4);
    @(negedge clk);
    chk(ctl_rdata == 32'd0, "R2 readback unchanged by window", int'(ctl_rdata), 0);
    chk(tx_valid == 1'b0, "R2 valid stays low", int'(tx_valid), 0);

    // R3: commit 4
    commit(4, 1'b0);
    chk(ctl_rdata == 32'h0004_0004, "R3 readback layout", int'(ctl_rdata), 32'h0004_0004);
    chk(tx_valid == 1'b1, "R5 valid with data", int'(tx_valid), 1);
    chk(tx_space == 1'b1, "R8 space below 128", int'(tx_space), 1);

    // R5/R4: drain with a steady ready
    drain(1'b0);
    chk(rd_fill() == 0, "R5 count after drain", rd_fill(), 0);
    chk(rd_wptr() == 4, "R3 pointer kept", rd_wptr(), 4);
    chk(tx_valid == 1'b0, "R10 empty means no valid", int'(tx_valid), 0);

    // R10: ready while empty has no effect
    @(posedge clk); #1 tx_ready = 1'b1;
    @(posedge clk); #1 tx_ready = 1'b0;
    @(negedge clk);
    chk(ctl_rdata == 32'h0000_0004, "R10 ready ignored when empty", int'(ctl_rdata), 4);

    // R8/R9: level compare
    stage(130);
    commit(130, 1'b0);
    chk(rd_fill() == 130, "R3 count 130", rd_fill(), 130);
    chk(tx_space == 1'b0, "R8 count 130 not below 128", int'(tx_space), 0);
    @(posedge clk); #1 cfg_level = 3'd7;
    @(negedge clk);
    chk(tx_space == 1'b1, "R8 code 7 threshold 512", int'(tx_space), 1);
    @(posedge clk); #1 cfg_space_en = 1'b0;
    @(negedge clk);
    chk(tx_space == 1'b0, "R9 enable low", int'(tx_space), 0);
    @(posedge clk); #1 cfg_space_en = 1'b1; cfg_level = 3'd5;

    // R6: commit of 10 with a simultaneous removal
    stage(10);
    commit(10, 1'b1);
    chk(rd_fill() == 139, "R6 commit and pop both counted", rd_fill(), 139);
    chk(rd_wptr() == 144, "R6 pointer", rd_wptr(), 144);

    // R7: oversized commit clipped to free space
    stage(881);
    commit(1000, 1'b0);
    chk(rd_fill() == CAP, "R7 count capped", rd_fill(), CAP);
    chk(rd_wptr() == exp_wp, "R7/R11 pointer by grant, wrapped", rd_wptr(), exp_wp);
    chk(exp_wp == 1, "R11 pointer wraps to 1", exp_wp, 1);
    commit(5, 1'b0);
    chk(rd_fill() == CAP, "R7 commit when full refused", rd_fill(), CAP);
    chk(rd_wptr() == 1, "R7 pointer unchanged when full", rd_wptr(), 1);

    // Drain everything with a toggling ready
    drain(1'b1);
    chk(rd_fill() == 0, "R5 final count", rd_fill(), 0);
    chk(expq.size() == 0, "R4 all bytes delivered", expq.size(), 0);
    chk(exp_fill == 0, "R5 model count", exp_fill, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule